// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block stores received frames, arriving one byte per beat, into a circular byte region of local memory. Each frame occupies a 4-byte-aligned slot: four header bytes followed by the frame bytes. The frame bytes go in as they arrive. The header is written last and carries a 16-bit status word and the 16-bit frame length, CRC included. Only then does the write offset move past the slot. A consumer sees new data only through that offset, so it can never see a partly written frame.

The consumer reports its progress through a pointer register that holds its offset minus a fixed guard distance. The block keeps the guard distance free between its own write offset and the consumer. It refuses any frame that would intrude into that gap. An empty flag is raised whenever the write offset equals the consumer offset. Four sticky event bits record stored frames, discarded bad frames, frames dropped for lack of space, and bytes lost while the header was being written. Each bit is cleared by writing a one to it.

Controller states: `ST_IDLE` (between frames), `ST_BODY` (storing frame bytes), `ST_SKIP` (discarding the rest of a dropped frame) and `ST_HEAD` (writing the four header bytes). Transitions:
- IDLE→BODY on a stored non-last byte.
- IDLE/BODY→HEAD on a last byte of a good frame.
- IDLE/BODY→IDLE on a last byte of a bad frame.
- IDLE/BODY→SKIP when a byte does not fit, or →IDLE if that byte is also the last one.
- SKIP→IDLE on the last byte.
- HEAD→IDLE after the fourth header byte, which commits the slot.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset:
  - the write offset is 0;
  - the consumer pointer register holds RING_BYTES-GUARD_BYTES, so the consumer offset is 0;
  - `buf_empty` is 1;
  - `irq_status` is 0;
  - `in_ready` is 1.
- R2: The header is stored little-endian at the slot start, so byte 0 holds status[7:0].
  - Header bits 15:0 hold the status word and bits 31:16 hold the length, which is the byte count including CRC.
  - Status bit 0 is `in_good`.
  - Status bits 1..5 are `in_err[0..4]`: alignment, CRC, too long, runt, bad symbol.
  - Status bits 13, 14 and 15 are `in_kind[0..2]`: broadcast, physical match, multicast.
  - Status bits 12:6 are 0.
- R3: Frame byte i is written at (slot + 4 + i) mod RING_BYTES, so payload wraps to the region start.
- R4: Committing a frame of length L advances the write offset by (L + 4) rounded up to a multiple of 4, modulo RING_BYTES.
- R5: A frame whose last byte carries `in_good`=0 is not committed, leaves the write offset unchanged and sets `irq_status[1]`.
- R6: Let free be (consumer − write) mod RING_BYTES, or RING_BYTES when the two are equal.
  - A frame is stored only if, for every prefix of n bytes, round4(n+4) < free.
  - Otherwise the frame is dropped, `irq_status[4]` is set and the write offset is unchanged.
- R7: The consumer offset is (pointer register + GUARD_BYTES) mod RING_BYTES, and `buf_empty` is 1 exactly when it equals the write offset.
- R8: `buf_empty` does not change while a frame is being stored or its header written; it changes only on commit or on a pointer write.
- R9: `in_ready` is 0 during the four header-write cycles.
  - A byte offered then is lost and does not start a frame.
  - It sets `irq_status[6]`.
- R10: Each committed frame sets `irq_status[0]`.
  - Writing a 1 to an `irq_status` bit through `irq_clr_data` clears it, and leaves other bits unchanged.
  - A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Last byte of frame |
| in_good | input | 1 | Frame good, valid with last byte |
| in_err | input | 5 | Error flags, valid with last byte |
| in_kind | input | 3 | Destination class flags, valid with last byte |
| in_ready | output | 1 | Byte accepted this cycle |
| mem_we | output | 1 | Ring memory byte write |
| mem_addr | output | OFF_W | Ring memory byte address |
| mem_wdata | output | 8 | Ring memory byte data |
| host_ptr_we | input | 1 | Consumer pointer register write |
| host_ptr_wdata | input | OFF_W | Consumer offset minus guard |
| wr_off | output | OFF_W | Committed write offset |
| buf_empty | output | 1 | No unread frame in ring |
| irq_clr_we | input | 1 | Event clear strobe |
| irq_clr_data | input | 8 | Write-one-to-clear mask |
| irq_status | output | 8 | Sticky events: bits 0, 1, 4, 6 |

## Verification
The bench builds the block with a 64-byte ring and the guard distance of 16. This keeps the real margin arithmetic intact while letting a few short frames fill the ring. It therefore reaches:
- payload wrap past the region end;
- the exact largest frame that fits an empty ring, and the one-byte-longer frame that is refused;
- a drop part way through a frame against an unmoved consumer.

The same small ring makes the biased pointer values wrap modulo the ring, which exercises the consumer-offset arithmetic.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_SKIP,
        ST_HEAD
    } wstate_e;

    localparam int IRQ_W    = 8;
    localparam int EV_ROK   = 0;
    localparam int EV_RERR  = 1;
    localparam int EV_OVF   = 4;
    localparam int EV_FIFO  = 6;

    // status word: good at 0, errors at 5:1, destination class at 15:13
    function automatic logic [15:0] pack_status(input logic good,
                                                input logic [4:0] err,
                                                input logic [2:0] kind);
        return {kind, 7'b0, err, good};
    endfunction

endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
    parameter int RING_BYTES  = 8192,
    parameter int GUARD_BYTES = 16,
    localparam int OFF_W      = $clog2(RING_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_ptr_we,
    input  logic [OFF_W-1:0] host_ptr_wdata,
    input  logic             commit,
    input  logic [OFF_W-1:0] commit_adv,
    output logic [OFF_W-1:0] wr_off,
    output logic [OFF_W:0]   free_bytes,
    output logic             buf_empty
);
    localparam logic [OFF_W-1:0] HOST_RST = OFF_W'(RING_BYTES - GUARD_BYTES);

    logic [OFF_W-1:0] wr_q;
    logic [OFF_W-1:0] host_q;
    logic [OFF_W-1:0] cons;
    logic [OFF_W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= '0;
            host_q <= HOST_RST;
        end else begin
            if (commit)      wr_q   <= wr_q + commit_adv;
            if (host_ptr_we) host_q <= host_ptr_wdata;
        end
    end

    always_comb begin
        cons       = host_q + OFF_W'(GUARD_BYTES);
        gap        = cons - wr_q;
        free_bytes = (gap == '0) ? (OFF_W+1)'(RING_BYTES) : {1'b0, gap};
        buf_empty  = (gap == '0);
        wr_off     = wr_q;
    end

    a_r4_wr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q[1:0] == 2'b00);

    a_r8_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !host_ptr_we) |=> $stable(buf_empty));

endmodule

// File: rtl/rxr_intr.sv
module rxr_intr
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] ev_set,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_data,
    output logic [IRQ_W-1:0] status
);
    logic [IRQ_W-1:0] st_q;
    logic [IRQ_W-1:0] clr_mask;

    always_comb begin
        clr_mask = clr_we ? clr_data : '0;
        status   = st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_mask) | ev_set;
    end

    a_r10_clear_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_data[EV_ROK] && !ev_set[EV_ROK]) |=> !status[EV_ROK]);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set[EV_ROK] |=> status[EV_ROK]);

endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
    import rxr_pkg::*;
#(
    parameter int RING_BYTES = 8192,
    localparam int OFF_W     = $clog2(RING_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             in_good,
    input  logic [4:0]       in_err,
    input  logic [2:0]       in_kind,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [OFF_W:0]   free_bytes,
    output logic             in_ready,
    output logic             mem_we,
    output logic [OFF_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             commit,
    output logic [OFF_W-1:0] commit_adv,
    output logic             ev_ok,
    output logic             ev_bad,
    output logic             ev_ovf,
    output logic             ev_fifo
);
    wstate_e     state_q, state_n;
    logic [15:0] cnt_q, cnt_n;
    logic [15:0] stat_q, stat_n;
    logic [1:0]  idx_q, idx_n;

    logic [16:0]      need;
    logic             fits;
    logic [31:0]      hdr_word;
    logic [OFF_W-1:0] pay_addr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            stat_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            stat_q  <= stat_n;
            idx_q   <= idx_n;
        end
    end

    // next state and outputs
    always_comb begin
        need       = ({1'b0, cnt_q} + 17'd8) & 17'h1FFFC;
        fits       = need < 17'(free_bytes);
        hdr_word   = {cnt_q, stat_q};
        pay_addr   = wr_off + cnt_q[OFF_W-1:0] + OFF_W'(4);
        commit_adv = (cnt_q[OFF_W-1:0] + OFF_W'(7)) & ~OFF_W'(3);

        state_n   = state_q;
        cnt_n     = cnt_q;
        stat_n    = stat_q;
        idx_n     = idx_q;
        in_ready  = (state_q != ST_HEAD);
        mem_we    = 1'b0;
        mem_addr  = pay_addr;
        mem_wdata = in_data;
        commit    = 1'b0;
        ev_ok     = 1'b0;
        ev_bad    = 1'b0;
        ev_ovf    = 1'b0;
        ev_fifo   = 1'b0;

        unique case (state_q)
            ST_IDLE, ST_BODY: begin
                if (in_valid) begin
                    if (fits) begin
                        mem_we = 1'b1;
                        cnt_n  = cnt_q + 16'd1;
                        if (!in_last) begin
                            state_n = ST_BODY;
                        end else if (in_good) begin
                            state_n = ST_HEAD;
                            idx_n   = 2'd0;
                            stat_n  = pack_status(in_good, in_err, in_kind);
                        end else begin
                            state_n = ST_IDLE;
                            ev_bad  = 1'b1;
                            cnt_n   = '0;
                        end
                    end else begin
                        ev_ovf  = 1'b1;
                        cnt_n   = '0;
                        state_n = in_last ? ST_IDLE : ST_SKIP;
                    end
                end
            end
            ST_SKIP: begin
                if (in_valid && in_last) state_n = ST_IDLE;
            end
            ST_HEAD: begin
                mem_we    = 1'b1;
                mem_addr  = wr_off + OFF_W'(idx_q);
                mem_wdata = hdr_word[{idx_q, 3'b000} +: 8];
                ev_fifo   = in_valid;
                if (idx_q == 2'd3) begin
                    commit  = 1'b1;
                    ev_ok   = 1'b1;
                    cnt_n   = '0;
                    state_n = ST_IDLE;
                end else begin
                    idx_n = idx_q + 2'd1;
                end
            end
        endcase
    end

    a_r6_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !mem_we);

    a_r6_drop_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovf |=> !commit);

    a_r8_commit_after_head: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(state_q) == ST_HEAD);

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int RING_BYTES  = 8192,
    parameter int GUARD_BYTES = 16,
    localparam int OFF_W      = $clog2(RING_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             in_good,
    input  logic [4:0]       in_err,
    input  logic [2:0]       in_kind,
    output logic             in_ready,
    output logic             mem_we,
    output logic [OFF_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic             host_ptr_we,
    input  logic [OFF_W-1:0] host_ptr_wdata,
    output logic [OFF_W-1:0] wr_off,
    output logic             buf_empty,
    input  logic             irq_clr_we,
    input  logic [7:0]       irq_clr_data,
    output logic [7:0]       irq_status
);
    logic [OFF_W:0]   free_bytes;
    logic             commit;
    logic [OFF_W-1:0] commit_adv;
    logic             ev_ok, ev_bad, ev_ovf, ev_fifo;
    logic [IRQ_W-1:0] ev_set;

    always_comb begin
        ev_set          = '0;
        ev_set[EV_ROK]  = ev_ok;
        ev_set[EV_RERR] = ev_bad;
        ev_set[EV_OVF]  = ev_ovf;
        ev_set[EV_FIFO] = ev_fifo;
    end

    rxr_writer #(.RING_BYTES(RING_BYTES)) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_good    (in_good),
        .in_err     (in_err),
        .in_kind    (in_kind),
        .wr_off     (wr_off),
        .free_bytes (free_bytes),
        .in_ready   (in_ready),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .commit     (commit),
        .commit_adv (commit_adv),
        .ev_ok      (ev_ok),
        .ev_bad     (ev_bad),
        .ev_ovf     (ev_ovf),
        .ev_fifo    (ev_fifo)
    );

    rxr_space #(.RING_BYTES(RING_BYTES), .GUARD_BYTES(GUARD_BYTES)) u_space (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_ptr_we    (host_ptr_we),
        .host_ptr_wdata (host_ptr_wdata),
        .commit         (commit),
        .commit_adv     (commit_adv),
        .wr_off         (wr_off),
        .free_bytes     (free_bytes),
        .buf_empty      (buf_empty)
    );

    rxr_intr u_intr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_set   (ev_set),
        .clr_we   (irq_clr_we),
        .clr_data (irq_clr_data),
        .status   (irq_status)
    );

    a_r9_fifo_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> irq_status[EV_FIFO]);

    a_r5_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bad |=> irq_status[EV_RERR] && $stable(wr_off));

endmodule

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
    localparam int CLK_PERIOD = 10;
    localparam int RING       = 64;
    localparam int OW         = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_last = 1'b0, in_good = 1'b0;
    logic [7:0]    in_data = '0;
    logic [4:0]    in_err = '0;
    logic [2:0]    in_kind = '0;
    logic          in_ready, mem_we, buf_empty;
    logic [OW-1:0] mem_addr, wr_off;
    logic [7:0]    mem_wdata, irq_status;
    logic          host_ptr_we = 1'b0, irq_clr_we = 1'b0;
    logic [OW-1:0] host_ptr_wdata = '0;
    logic [7:0]    irq_clr_data = '0;

    logic [7:0] mem [RING];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    rx_ring_writer #(.RING_BYTES(RING), .GUARD_BYTES(16)) i_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_good(in_good), .in_err(in_err), .in_kind(in_kind),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .host_ptr_we(host_ptr_we),
        .host_ptr_wdata(host_ptr_wdata), .wr_off(wr_off), .buf_empty(buf_empty),
        .irq_clr_we(irq_clr_we), .irq_clr_data(irq_clr_data),
        .irq_status(irq_status));

    typedef struct packed {
        logic          rd_we;
        logic [OW-1:0] rd_val;
        logic [7:0]    len;
        logic          good;
        logic [4:0]    err;
        logic [2:0]    kind;
        logic          stored;
        logic [OW-1:0] exp_wr;
        logic [7:0]    exp_irq;
        logic [15:0]   exp_stat;
        logic          chk_mid_empty;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'h00, 8'd10, 1'b1, 5'b00000, 3'b001, 1'b1, 6'd16, 8'h01, 16'h2001, 1'b0},
        '{1'b0, 6'h00, 8'd12, 1'b0, 5'b00010, 3'b000, 1'b0, 6'd16, 8'h02, 16'h0000, 1'b0},
        '{1'b0, 6'h00, 8'd20, 1'b1, 5'b00100, 3'b010, 1'b1, 6'd40, 8'h01, 16'h4009, 1'b0},
        '{1'b0, 6'h00, 8'd30, 1'b1, 5'b00000, 3'b000, 1'b0, 6'd40, 8'h10, 16'h0000, 1'b0},
        '{1'b1, 6'h00, 8'd30, 1'b1, 5'b00000, 3'b100, 1'b1, 6'd12, 8'h01, 16'h8001, 1'b0},
        '{1'b1, 6'h3C, 8'd56, 1'b1, 5'b10000, 3'b000, 1'b1, 6'd8,  8'h01, 16'h0021, 1'b1},
        '{1'b1, 6'h38, 8'd57, 1'b1, 5'b00000, 3'b000, 1'b0, 6'd8,  8'h10, 16'h0000, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int seed, input int i);
        return 8'(i * 3 + seed * 7 + 1);
    endfunction

    task automatic send(input int len, input logic good, input logic [4:0] err,
                        input logic [2:0] kind, input int seed, input bit extra,
                        output logic mid_empty, output logic mid_ready);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pbyte(seed, i); in_last = (i == len - 1);
            in_good = good; in_err = err; in_kind = kind;
        end
        @(negedge clk);
        in_valid = extra; in_last = 1'b0; in_data = 8'hEE;
        @(negedge clk);
        in_valid = 1'b0;
        mid_empty = buf_empty; mid_ready = in_ready;
        repeat (5) @(negedge clk);
    endtask

    task automatic wr_ptr(input logic [OW-1:0] v);
        @(negedge clk); host_ptr_we = 1'b1; host_ptr_wdata = v;
        @(negedge clk); host_ptr_we = 1'b0;
    endtask

    task automatic clr_irq(input logic [7:0] m);
        @(negedge clk); irq_clr_we = 1'b1; irq_clr_data = m;
        @(negedge clk); irq_clr_we = 1'b0;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int prev_wr, cons, bad;
        logic me, mr;
        for (int i = 0; i < RING; i++) mem[i] = 8'h00;
        prev_wr = 0; cons = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 wr_off", 32'(wr_off), 0);
        chk("R1 empty", 32'(buf_empty), 1);
        chk("R1 irq", 32'(irq_status), 0);
        chk("R1 ready", 32'(in_ready), 1);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v].rd_we) begin
                wr_ptr(VEC[v].rd_val);
                cons = (int'(VEC[v].rd_val) + 16) % RING;
            end
            send(int'(VEC[v].len), VEC[v].good, VEC[v].err, VEC[v].kind, v, 1'b0, me, mr);
            chk($sformatf("R4/R5/R6 wr_off vec%0d", v), 32'(wr_off), 32'(VEC[v].exp_wr));
            chk($sformatf("R5/R6/R10 irq vec%0d", v), 32'(irq_status), 32'(VEC[v].exp_irq));
            chk($sformatf("R7 empty vec%0d", v), 32'(buf_empty),
                32'(int'(VEC[v].exp_wr) == cons));
            if (VEC[v].chk_mid_empty)
                chk("R8 empty held during header", 32'(me), 1);
            if (VEC[v].stored) begin
                chk($sformatf("R2 header vec%0d", v),
                    {mem[prev_wr+3], mem[prev_wr+2], mem[prev_wr+1], mem[prev_wr]},
                    {8'h00, VEC[v].len, VEC[v].exp_stat});
                bad = 0;
                for (int i = 0; i < int'(VEC[v].len); i++)
                    if (mem[(prev_wr + 4 + i) % RING] !== pbyte(v, i)) bad++;
                chk($sformatf("R3 payload mismatches vec%0d", v), 32'(bad), 0);
            end
            prev_wr = int'(VEC[v].exp_wr);
            clr_irq(8'hFF);
        end

        // R9: byte offered during header write is lost and flagged
        send(8, 1'b1, 5'b0, 3'b0, 9, 1'b1, me, mr);
        chk("R9 ready low in header", 32'(mr), 0);
        chk("R9 wr_off after frame", 32'(wr_off), 20);
        chk("R9 irq fifo+ok", 32'(irq_status), 32'h41);
        chk("R2 header len8", {mem[11], mem[10], mem[9], mem[8]}, 32'h0008_0001);
        // R10: clear only bit 6
        clr_irq(8'h40);
        chk("R10 w1c selective", 32'(irq_status), 32'h01);
        // R9: stray byte did not begin a frame
        send(4, 1'b1, 5'b0, 3'b0, 10, 1'b0, me, mr);
        chk("R9 next frame aligned", 32'(wr_off), 28);
        chk("R2 header len4", {mem[23], mem[22], mem[21], mem[20]}, 32'h0004_0001);
        // R7: consumer catches up
        wr_ptr(6'd12);
        chk("R7 empty after catch-up", 32'(buf_empty), 1);
        summary();
    end
endmodule